// File: doc/BRIEF.md
# RGMII Receive Timing Adjust Sampler

This block retimes the five receive-side inputs of an RGMII port (the control line and the four data lines) against the double-data-rate receive clock. It works in a separate, faster timing-adjustment clock domain. The receive clock is brought into that domain through a synchronizer, and each of its transitions restarts a phase counter. In adjust mode, the five lanes are captured when the counter reaches a target. Lanes marked in a skew mask are captured one fast cycle later, which cancels late-arriving board traces. Captures that follow a rising receive edge go to one output vector and captures that follow a falling edge go to another.

The target comes from a programmed delay code or, with auto-setup, from half of the most recently measured half-period. With adjustment disabled, the lanes are captured directly at the cycle in which the edge is detected. If a receive edge arrives before an armed capture has happened, a sticky flag records the lost sample.

Lane order on `rx_lanes` and `skew_mask`: index 0 is the control line, index 1 is data bit 3, index 2 data bit 2, index 3 data bit 1 and index 4 data bit 0.

Top module: `rgmii_rx_retimer`

## Requirements
- R1: While `rst_n` is low, `rise_q`, `fall_q` and `miss_flag` are all zero.
- R2: With `adj_en` = 0, every lane is sampled at the fast-clock edge E0+2, where E0 is the first fast-clock rising edge at which `rx_clk` shows its new level.
- R3: With `adj_en` = 1 and `auto_setup` = 0, a lane whose `skew_mask` bit is 0 is sampled at fast-clock edge E0+3+D, where D = `dly_code`. D is valid up to H-2, where H is the receive half-period in fast cycles.
- R4: With `adj_en` = 1, a lane whose `skew_mask` bit is 1 is sampled at E0+4+T, one fast cycle after the other lanes. T is the active target. `skew_mask` bit i belongs to `rx_lanes` bit i. With `adj_en` = 0, `skew_mask` has no effect.
- R5: With `adj_en` = 1 and `auto_setup` = 1, `dly_code` is ignored and the target is floor(M/2). M is the number of fast cycles between the two most recent detected edges, minus one. The first half-period after reset uses target 0.
- R6: A sample taken for a rising `rx_clk` edge updates only `rise_q`, and a sample for a falling edge updates only `fall_q`. Each holds its value until the next sample for its own edge type.
- R7: In adjust mode, if an edge is detected while the previous half-period's capture is still pending, `miss_flag` goes to 1. It stays at 1 until reset and is never set while `adj_en` = 0.
- R8: With `adj_en` = 0, `auto_setup` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_adj | input | 1 | Fast timing-adjustment clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk | input | 1 | Receive clock, sampled as data in the fast domain |
| rx_lanes | input | LANES | Raw control and data lanes |
| adj_en | input | 1 | 1 = counter-timed capture, 0 = bypass |
| auto_setup | input | 1 | 1 = target from measured half-period |
| dly_code | input | DLY_W | Programmed capture delay in fast cycles |
| skew_mask | input | LANES | Per-lane one-cycle extra delay |
| rise_q | output | LANES | Lanes captured for the rising receive edge |
| fall_q | output | LANES | Lanes captured for the falling receive edge |
| miss_flag | output | 1 | Sticky lost-sample indicator |

## Verification
The bench builds the block with its defaults: five lanes, a 5-bit delay code and a two-stage synchronizer. With those values the bench's receive half-periods of 6 to 20 fast cycles lie both inside and outside the delay code's range. Codes can therefore sit exactly on the last legal count, where the skewed lane lands on the next clearing edge, and also beyond it, where a miss must occur. Each lane carries a different cycle-indexed pattern, so a capture that is one fast cycle early or late on any single lane changes the observed vector.

// File: rtl/rgrt_pkg.sv
package rgrt_pkg;
  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } rx_phase_e;

  function automatic int unsigned cnt_width(input int unsigned dly_w);
    return dly_w + 1;
  endfunction
endpackage

// File: rtl/rgrt_edge_det.sv
module rgrt_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_p,
  output logic fall_p
);
  logic [SYNC_STAGES:0] chain_q;
  logic [SYNC_STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise_p =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall_p = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/rgrt_phase_ctr.sv
module rgrt_phase_ctr #(
  parameter int unsigned DLY_W = 5,
  localparam int unsigned CNT_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_p,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] half_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             seen_q, seen_d;
  logic             half_en;

  always_comb begin
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    half_en = edge_p & seen_q;
    half_d  = cnt_q;
    if (edge_p) begin
      cnt_d  = '0;
      seen_d = 1'b1;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= '0;
    else if (half_en) half_q <= half_d;
  end

  assign cnt_o  = cnt_q;
  assign half_o = half_q;
endmodule

// File: rtl/rgrt_sched.sv
module rgrt_sched
  import rgrt_pkg::*;
#(
  parameter int unsigned DLY_W = 5,
  localparam int unsigned CNT_W = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adj_en,
  input  logic             auto_en,
  input  logic [DLY_W-1:0] dly_code,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] half_len,
  input  logic             edge_p,
  input  logic             edge_rise,
  output logic             base_hit,
  output rx_phase_e        base_ph,
  output logic             late_hit,
  output rx_phase_e        late_ph,
  output logic             miss
);
  logic [DLY_W-1:0] tgt;
  logic             match;
  rx_phase_e        ph_q, ph_d, late_ph_q;
  logic             armed_q, armed_d;
  logic             late_q;
  logic             miss_q, miss_d;

  always_comb begin
    tgt   = (adj_en && auto_en) ? half_len[CNT_W-1:1] : dly_code;
    match = armed_q && !edge_p && (cnt == {1'b0, tgt});
    ph_d  = edge_p ? (edge_rise ? PH_RISE : PH_FALL) : ph_q;
    if (edge_p)     armed_d = adj_en;
    else if (match) armed_d = 1'b0;
    else            armed_d = armed_q;
    miss_d = miss_q | (edge_p & armed_q & adj_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_FALL;
      armed_q   <= 1'b0;
      late_q    <= 1'b0;
      late_ph_q <= PH_FALL;
      miss_q    <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      armed_q   <= armed_d;
      late_q    <= adj_en & match;
      late_ph_q <= ph_q;
      miss_q    <= miss_d;
    end
  end

  assign base_hit = adj_en ? match : edge_p;
  assign base_ph  = adj_en ? ph_q : (edge_rise ? PH_RISE : PH_FALL);
  assign late_hit = late_q;
  assign late_ph  = late_ph_q;
  assign miss     = miss_q;
endmodule

// File: rtl/rgmii_rx_retimer.sv
module rgmii_rx_retimer
  import rgrt_pkg::*;
#(
  parameter int unsigned LANES       = 5,
  parameter int unsigned DLY_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_adj,
  input  logic             rst_n,
  input  logic             rx_clk,
  input  logic [LANES-1:0] rx_lanes,
  input  logic             adj_en,
  input  logic             auto_setup,
  input  logic [DLY_W-1:0] dly_code,
  input  logic [LANES-1:0] skew_mask,
  output logic [LANES-1:0] rise_q,
  output logic [LANES-1:0] fall_q,
  output logic             miss_flag
);
  localparam int unsigned CNT_W = cnt_width(DLY_W);

  logic [1:0]       rst_pipe;
  logic             rst_i_n;
  logic             edge_rise, edge_fall, edge_any;
  logic [CNT_W-1:0] cnt, half_len;
  logic             base_hit, late_hit;
  rx_phase_e        base_ph, late_ph;

  always_ff @(posedge clk_adj or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  rgrt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk_adj), .rst_n(rst_i_n), .async_in(rx_clk),
    .rise_p(edge_rise), .fall_p(edge_fall)
  );
  assign edge_any = edge_rise | edge_fall;

  rgrt_phase_ctr #(.DLY_W(DLY_W)) ctr_i (
    .clk(clk_adj), .rst_n(rst_i_n), .edge_p(edge_any),
    .cnt_o(cnt), .half_o(half_len)
  );

  rgrt_sched #(.DLY_W(DLY_W)) sched_i (
    .clk(clk_adj), .rst_n(rst_i_n), .adj_en(adj_en), .auto_en(auto_setup),
    .dly_code(dly_code), .cnt(cnt), .half_len(half_len),
    .edge_p(edge_any), .edge_rise(edge_rise),
    .base_hit(base_hit), .base_ph(base_ph),
    .late_hit(late_hit), .late_ph(late_ph), .miss(miss_flag)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic      use_late, hit;
    rx_phase_e ph;
    logic      rise_en, fall_en;
    logic      r_q, f_q;

    always_comb begin
      use_late = adj_en & skew_mask[l];
      hit      = use_late ? late_hit : base_hit;
      ph       = use_late ? late_ph  : base_ph;
      rise_en  = hit & (ph == PH_RISE);
      fall_en  = hit & (ph == PH_FALL);
    end

    always_ff @(posedge clk_adj or negedge rst_i_n) begin
      if (!rst_i_n)     r_q <= 1'b0;
      else if (rise_en) r_q <= rx_lanes[l];
    end

    always_ff @(posedge clk_adj or negedge rst_i_n) begin
      if (!rst_i_n)     f_q <= 1'b0;
      else if (fall_en) f_q <= rx_lanes[l];
    end

    assign rise_q[l] = r_q;
    assign fall_q[l] = f_q;
  end
endmodule

// File: rtl/rgmii_rx_retimer_chk.sv
module rgmii_rx_retimer_chk #(
  parameter int unsigned LANES = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adj_en,
  input logic [LANES-1:0] skew_mask,
  input logic [LANES-1:0] rise_q,
  input logic [LANES-1:0] fall_q,
  input logic             miss,
  input logic             edge_p
);
  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> miss);

  assert_miss_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss) |-> $past(edge_p));

  assert_one_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rise_q) |-> $stable(fall_q));

  assert_bypass_at_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!adj_en) && (!$stable(rise_q) || !$stable(fall_q))) |-> $past(edge_p));

  assert_adjust_off_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adj_en) && $stable(skew_mask) &&
     ((((rise_q ^ $past(rise_q)) | (fall_q ^ $past(fall_q))) & ~skew_mask) != '0))
    |-> !$past(edge_p));
endmodule

bind rgmii_rx_retimer rgmii_rx_retimer_chk #(.LANES(LANES)) chk_i (
  .clk(clk_adj), .rst_n(rst_n), .adj_en(adj_en), .skew_mask(skew_mask),
  .rise_q(rise_q), .fall_q(fall_q), .miss(miss_flag), .edge_p(edge_any)
);

// File: tb/rgmii_rx_retimer_tb_top.sv
module rgmii_rx_retimer_tb_top;
  logic       clk_adj = 1'b0;
  logic       rst_n;
  logic       rx_clk;
  logic [4:0] rx_lanes;
  logic       adj_en, auto_setup;
  logic [4:0] dly_code, skew_mask;
  logic [4:0] rise_q, fall_q;
  logic       miss_flag;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int last_k0 [2];

  always #2 clk_adj = ~clk_adj;

  rgmii_rx_retimer dut_i (
    .clk_adj(clk_adj), .rst_n(rst_n), .rx_clk(rx_clk), .rx_lanes(rx_lanes),
    .adj_en(adj_en), .auto_setup(auto_setup), .dly_code(dly_code),
    .skew_mask(skew_mask), .rise_q(rise_q), .fall_q(fall_q), .miss_flag(miss_flag)
  );

  function automatic logic [4:0] pat(input int k);
    int v;
    v = (k * 37) ^ ((k >> 2) * 11) ^ (k >> 4);
    return v[4:0];
  endfunction

  function automatic logic [4:0] expect_vec(input int k0, input bit en, input int tgt,
                                            input logic [4:0] sk);
    logic [4:0] e;
    logic [4:0] p;
    for (int l = 0; l < 5; l++) begin
      if (!en) p = pat(k0 + 2);
      else     p = pat(k0 + 3 + tgt + (sk[l] ? 1 : 0));
      e[l] = p[l];
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_adj);
    n++;
    rx_lanes = pat(n);
  endtask

  task automatic run_seg(input int hp, input bit en, input bit au, input int dly,
                         input logic [4:0] sk, input bit do_rst, input bit exp_miss,
                         input string tag);
    int tgt;
    logic lvl;
    logic [4:0] got, exp;
    adj_en = en; auto_setup = au; dly_code = dly[4:0]; skew_mask = sk;
    if (do_rst) begin
      rst_n = 1'b0;
      rx_clk = 1'b0;
      step();
      // R1: reset state
      chk(rise_q == 5'd0 && fall_q == 5'd0 && miss_flag == 1'b0, "R1",
          {rise_q, fall_q, 1'b0, miss_flag}, 0);
      step(); step();
      rst_n = 1'b1;
    end
    last_k0[0] = -1; last_k0[1] = -1;
    tgt = (en && au) ? (hp - 1) >> 1 : dly;
    for (int t = 0; t < 10; t++) begin
      repeat (hp) step();
      lvl = ~rx_clk;
      if (t >= 4 && !exp_miss) begin
        exp = expect_vec(last_k0[lvl ? 1 : 0], en, tgt, sk);
        got = lvl ? rise_q : fall_q;
        chk(got == exp, tag, int'(got), int'(exp));
      end
      rx_clk = lvl;
      last_k0[lvl ? 1 : 0] = n;
    end
    repeat (hp) step();
    chk(miss_flag == exp_miss, "R7", int'(miss_flag), int'(exp_miss));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_adj);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int hp;
    int dly;
    bit en, au;
    logic [4:0] sk;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; rx_clk = 1'b0; rx_lanes = '0;
    adj_en = 1'b0; auto_setup = 1'b0; dly_code = '0; skew_mask = '0;

    run_seg(10, 0, 0, 0,  5'b10101, 1, 0, "R2 R4 R6 bypass, mask ignored");
    run_seg(10, 1, 0, 0,  5'b00000, 1, 0, "R3 R6 delay 0");
    run_seg(10, 1, 0, 8,  5'b11111, 1, 0, "R3 R4 delay at H-2, all skewed");
    run_seg(14, 1, 0, 5,  5'b00001, 1, 0, "R4 skew on control lane");
    run_seg(14, 1, 0, 5,  5'b10000, 1, 0, "R4 skew on data bit 0 lane");
    run_seg(12, 1, 1, 31, 5'b01010, 1, 0, "R5 auto target, code ignored");
    run_seg(9,  0, 1, 3,  5'b00000, 1, 0, "R8 auto ignored in bypass");
    run_seg(6,  0, 0, 31, 5'b00000, 1, 0, "R2 R7 large code in bypass");
    run_seg(12, 1, 0, 20, 5'b00000, 1, 1, "R7 code beyond half-period");
    run_seg(12, 1, 0, 3,  5'b00000, 0, 1, "R7 sticky after recovery");

    for (int i = 0; i < 10; i++) begin
      hp  = $urandom_range(20, 6);
      en  = 1'($urandom_range(1, 0));
      au  = 1'($urandom_range(1, 0));
      dly = $urandom_range(hp - 2, 0);
      sk  = 5'($urandom);
      run_seg(hp, en, au, dly, sk, 1, 0, "R2 R3 R4 R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule